// File: doc/BRIEF.md
# Timer Count-Clock Prescaler with Edge-Selectable Inputs

This block supplies the count-enable for a 16-bit timer. It makes a pulse one system clock wide, either from a free-running divider of the system clock or from qualified transitions on external input 0. A 3-bit clock-select code picks the source. Six codes select divider taps of uneven spacing: /2, /4, /16, /32, /128 and /256. One code selects the external input instead.

Alongside the count-enable, the block watches two asynchronous input pins. Each pin has a 2-bit sensitivity field that selects falling, rising or both transitions. Each qualified transition is reported as a one-cycle event while the timer runs. A pin that is already high when the timer is first started after reset produces one immediate rising event. A later stop and restart produces none.

Configuration is written over a simple register bus to two registers. Writes are honoured only while the timer is stopped. A write made while the timer runs, or a write that leaves a forbidden code in place, sets a sticky error flag.

Top module: `tmr_prescaler`

## Requirements
- R1: After reset both registers read 0x00, the error flag and all outputs are low, and the clock-select code is 000, so the default count clock is system clock /2.
- R2: With internal code c held while running, cnt_en_o pulses for exactly one cycle once every N system clocks. The mapping is 000→2, 001→4, 010→16, 100→32, 101→128 and 110→256, so a 1024-cycle window holds exactly 1024/N pulses.
- R3: When run_i is first sampled high at a clock edge, the divider restarts from zero and the first count pulse is visible after N+1 rising edges, counting that edge.
- R4: With code 011, each qualified transition on pin 0 under its sensitivity field gives exactly one count pulse.
- R5: The sensitivity fields sit at register-0 bits 5:4 for pin 0 and bits 7:6 for pin 1. Code 00 is falling, 01 is rising and 11 is both. Each qualified transition gives one edge_evt_o pulse on that pin's bit only, and no events occur while run_i is low.
- R6: When a pin is high after reset and the timer is started for the first time with rising or both-edge sensitivity, exactly one rising event is reported.
- R7: When the timer is stopped and restarted while a pin stays high, no event is reported.
- R8: A register write while run_i is high changes no register content and sets err_o. err_o stays set until reset.
- R9: A write that leaves a forbidden code sets err_o, while the written value is still stored. Code 111 is forbidden for the clock select and 10 for a sensitivity field. While code 111 is held, cnt_en_o stays low. While a pin's field is 10, that pin reports no events.
- R10: Register 0 (address 0) reads {sel1[1:0], sel0[1:0], 2'b00, code[1:0]}. Register 1 (address 1) reads {7'b0, code[2]}. A legal write while stopped leaves err_o low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 mode register, 1 extension register |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| run_i | input | 1 | Timer running |
| pin_i | input | 2 | Asynchronous external input pins |
| edge_evt_o | output | 2 | One-cycle qualified-transition event per pin |
| cnt_en_o | output | 1 | One-cycle count-enable for the timer |
| err_o | output | 1 | Sticky configuration error |

## Verification
The bench runs every divider code and checks two things for each: the exact latency to the first pulse after start, and the pulse count over a window of 1024 cycles. A divider that did not restart, or that used a wrong tap, would miss the latency or give the wrong count.

It runs every legal sensitivity code on both pins, with a waveform that has one more rise than fall. A swapped polarity or a missed both-edge case would then show up as a count that is off by one or out by half.

It goes after the reset-time rising quirk and the restart that must not repeat it, since a detector that always reloads, or never reloads, fails one of the two. It also checks that writes made while running and forbidden codes leave the stored value and the outputs as required.

// File: rtl/tpre_pkg.sv
package tpre_pkg;

    localparam int REG_W  = 8;
    localparam int DIV_W  = 8;
    localparam int NPIN   = 2;
    localparam int CSEL_W = 3;

    typedef enum logic [1:0] {
        EDG_FALL = 2'b00,
        EDG_RISE = 2'b01,
        EDG_BAD  = 2'b10,
        EDG_BOTH = 2'b11
    } edge_sel_e;

    typedef enum logic [CSEL_W-1:0] {
        CK_D2   = 3'd0,
        CK_D4   = 3'd1,
        CK_D16  = 3'd2,
        CK_EXT  = 3'd3,
        CK_D32  = 3'd4,
        CK_D128 = 3'd5,
        CK_D256 = 3'd6,
        CK_BAD  = 3'd7
    } clk_sel_e;

    typedef struct packed {
        logic [1:0] sel1;
        logic [1:0] sel0;
        logic [1:0] cs_lo;
        logic       cs_hi;
        logic       err;
    } cfg_t;

    // Low-bit mask of the divider tap chosen by a clock-select code
    function automatic logic [DIV_W-1:0] tap_mask(input clk_sel_e c);
        logic [DIV_W-1:0] m;
        case (c)
            CK_D2:   m = DIV_W'(1);
            CK_D4:   m = DIV_W'(3);
            CK_D16:  m = DIV_W'(15);
            CK_D32:  m = DIV_W'(31);
            CK_D128: m = DIV_W'(127);
            CK_D256: m = DIV_W'(255);
            default: m = '0;
        endcase
        return m;
    endfunction

    function automatic logic cfg_bad(input cfg_t c);
        return (c.sel1 == EDG_BAD) || (c.sel0 == EDG_BAD) ||
               ({c.cs_hi, c.cs_lo} == CK_BAD);
    endfunction

    function automatic logic edge_hit(input logic prev, input logic cur,
                                      input logic [1:0] sel);
        logic h;
        case (sel)
            EDG_FALL: h = prev & ~cur;
            EDG_RISE: h = ~prev & cur;
            EDG_BOTH: h = prev ^ cur;
            default:  h = 1'b0;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/tpre_regs.sv
module tpre_regs
    import tpre_pkg::*;
#(
    parameter int W   = REG_W,
    parameter int NP  = NPIN,
    parameter int CSW = CSEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              addr_i,
    input  logic [W-1:0]      wdata_i,
    input  logic              run_i,
    output logic [W-1:0]      rdata_o,
    output logic [NP-1:0][1:0] sel_o,
    output logic [CSW-1:0]    csel_o,
    output logic              err_o
);

    cfg_t r_d, r_q;
    cfg_t cand;
    logic unused_wbits;

    assign unused_wbits = ^wdata_i[3:2];

    always_comb begin
        r_d  = r_q;
        cand = r_q;
        if (wr_i) begin
            if (run_i) begin
                r_d.err = 1'b1;
            end else begin
                if (addr_i == 1'b0) begin
                    cand.sel1  = wdata_i[7:6];
                    cand.sel0  = wdata_i[5:4];
                    cand.cs_lo = wdata_i[1:0];
                end else begin
                    cand.cs_hi = wdata_i[0];
                end
                r_d = cand;
                if (cfg_bad(cand)) begin
                    r_d.err = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rdata_o  = (addr_i == 1'b0) ? {r_q.sel1, r_q.sel0, 2'b00, r_q.cs_lo}
                                       : {{(W-1){1'b0}}, r_q.cs_hi};
    assign sel_o[0] = r_q.sel0;
    assign sel_o[1] = r_q.sel1;
    assign csel_o   = {r_q.cs_hi, r_q.cs_lo};
    assign err_o    = r_q.err;

    // R8
    wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && run_i) |=> ($stable({r_q.sel1, r_q.sel0, r_q.cs_lo, r_q.cs_hi}) && err_o));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

endmodule

// File: rtl/tpre_edge.sv
module tpre_edge
    import tpre_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  logic       run_i,
    input  logic [1:0] sel_i,
    output logic       det_o,
    output logic       evt_o
);

    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
        logic seen;
        logic evt;
    } edg_t;

    edg_t e_d, e_q;
    logic det;

    always_comb begin
        det        = run_i && edge_hit(e_q.prev, e_q.s2, sel_i);
        e_d.s1     = pin_i;
        e_d.s2     = e_q.s1;
        // the stored level is frozen at 0 until the first run, then tracks
        e_d.prev   = (run_i || e_q.seen) ? e_q.s2 : e_q.prev;
        e_d.seen   = e_q.seen | run_i;
        e_d.evt    = det;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '0;
        end else begin
            e_q <= e_d;
        end
    end

    assign det_o = det;
    assign evt_o = e_q.evt;

    // R5
    evt_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> $past(run_i));

    // R9
    bad_sel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == EDG_BAD) |=> !evt_o);

endmodule

// File: rtl/tpre_div.sv
module tpre_div
    import tpre_pkg::*;
#(
    parameter int DW  = DIV_W,
    parameter int CSW = CSEL_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run_i,
    input  logic [CSW-1:0] csel_i,
    input  logic           ext_det_i,
    output logic           cnt_en_o
);

    typedef struct packed {
        logic [DW-1:0] cnt;
        logic          run;
        logic          en;
    } div_t;

    div_t d_d, d_q;
    clk_sel_e      sel;
    logic [DW-1:0] mask;

    assign sel  = clk_sel_e'(csel_i);
    assign mask = tap_mask(sel);

    always_comb begin
        d_d.run = run_i;
        if (run_i && !d_q.run) begin
            d_d.cnt = '0;
        end else begin
            d_d.cnt = d_q.cnt + 1'b1;
        end
        case (sel)
            CK_EXT:  d_d.en = ext_det_i;
            CK_BAD:  d_d.en = 1'b0;
            default: d_d.en = run_i && d_q.run && ((d_q.cnt & mask) == mask);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_q <= '0;
        end else begin
            d_q <= d_d;
        end
    end

    assign cnt_en_o = d_q.en;

    // R9
    bad_code_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == CK_BAD) |=> !cnt_en_o);

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel != CK_EXT) && cnt_en_o) |=> !cnt_en_o);

    // R2
    stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !cnt_en_o);

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tpre_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr_i,
    input  logic            reg_addr_i,
    input  logic [REG_W-1:0] reg_wdata_i,
    output logic [REG_W-1:0] reg_rdata_o,
    input  logic            run_i,
    input  logic [NPIN-1:0] pin_i,
    output logic [NPIN-1:0] edge_evt_o,
    output logic            cnt_en_o,
    output logic            err_o
);

    logic [NPIN-1:0][1:0]  sel;
    logic [CSEL_W-1:0]     csel;
    logic [NPIN-1:0]       det;

    tpre_regs #(.W(REG_W), .NP(NPIN), .CSW(CSEL_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .run_i   (run_i),
        .rdata_o (reg_rdata_o),
        .sel_o   (sel),
        .csel_o  (csel),
        .err_o   (err_o)
    );

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        tpre_edge u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .pin_i (pin_i[p]),
            .run_i (run_i),
            .sel_i (sel[p]),
            .det_o (det[p]),
            .evt_o (edge_evt_o[p])
        );
    end

    logic unused_det;
    assign unused_det = ^det[NPIN-1:1];

    tpre_div #(.DW(DIV_W), .CSW(CSEL_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run_i),
        .csel_i    (csel),
        .ext_det_i (det[0]),
        .cnt_en_o  (cnt_en_o)
    );

endmodule

// File: tb/test_tmr_prescaler.sv
module test_tmr_prescaler;

    localparam time TCK = 20ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = '0;
    logic       run = 1'b0;
    logic [1:0] pin = '0;
    logic [7:0] rdata;
    logic [1:0] evt;
    logic       ce;
    logic       err;

    int checks = 0;
    int errors = 0;
    int n_ce = 0, n_e0 = 0, n_e1 = 0, n_dbl = 0;
    logic ce_prev = 1'b0;

    tmr_prescaler i_tmr_prescaler (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_i    (wr),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .run_i       (run),
        .pin_i       (pin),
        .edge_evt_o  (evt),
        .cnt_en_o    (ce),
        .err_o       (err)
    );

    always #(TCK/2) clk = ~clk;

    always begin
        @(posedge clk);
        #5;
        if (ce) n_ce++;
        if (evt[0]) n_e0++;
        if (evt[1]) n_e1++;
        if (ce && ce_prev) n_dbl++;
        ce_prev = ce;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] p);
        rst_n = 1'b0; run = 1'b0; wr = 1'b0; pin = p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic a, output int v);
        addr = a;
        #1;
        v = int'(rdata);
    endtask

    task automatic win(input int n, output int dce, output int de0, output int de1, output int ddbl);
        int b_ce, b_e0, b_e1, b_dbl;
        b_ce = n_ce; b_e0 = n_e0; b_e1 = n_e1; b_dbl = n_dbl;
        repeat (n) @(negedge clk);
        dce = n_ce - b_ce; de0 = n_e0 - b_e0; de1 = n_e1 - b_e1; ddbl = n_dbl - b_dbl;
    endtask

    // r rises and r-1 falls on one pin, ending high
    task automatic wave(input int idx, input int r, input int hold,
                        output int dce, output int de0, output int de1);
        int b_ce, b_e0, b_e1;
        b_ce = n_ce; b_e0 = n_e0; b_e1 = n_e1;
        for (int i = 0; i < r; i++) begin
            pin[idx] = 1'b1;
            repeat (hold) @(negedge clk);
            if (i < r - 1) begin
                pin[idx] = 1'b0;
                repeat (hold) @(negedge clk);
            end
        end
        repeat (6) @(negedge clk);
        dce = n_ce - b_ce; de0 = n_e0 - b_e0; de1 = n_e1 - b_e1;
    endtask

    task automatic park();
        run = 1'b0;
        repeat (2) @(negedge clk);
        pin = 2'b00;
        repeat (6) @(negedge clk);
    endtask

    function automatic int divisor(input int code);
        case (code)
            0: return 2;
            1: return 4;
            2: return 16;
            4: return 32;
            5: return 128;
            default: return 256;
        endcase
    endfunction

    initial begin
        #(TCK * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v, dce, de0, de1, ddbl, k;
        int codes[6] = '{0, 1, 2, 4, 5, 6};
        int sels[3]  = '{0, 1, 3};

        // R1 reset state, pin 0 held high through reset
        do_reset(2'b01);
        rd_reg(1'b0, v); chk("R1 mode reg", v, 0);
        rd_reg(1'b1, v); chk("R1 ext reg", v, 0);
        chk("R1 err", int'(err), 0);
        chk("R1 cnt_en", int'(ce), 0);
        chk("R1 evt", int'(evt), 0);

        // R6 first run after reset with pin high and rising sensitivity
        wr_reg(1'b0, 8'h10);
        @(negedge clk); run = 1'b1;
        win(20, dce, de0, de1, ddbl);
        chk("R6 first-run rising event", de0, 1);
        chk("R6 other pin quiet", de1, 0);

        // R1 default code gives /2
        win(1024, dce, de0, de1, ddbl);
        chk("R1 default /2 count", dce, 512);
        chk("R2 default width", ddbl, 0);

        // R8 write while running is ignored
        wr_reg(1'b0, 8'hC1);
        rd_reg(1'b0, v); chk("R8 mode unchanged", v, 8'h10);
        chk("R8 err set", int'(err), 1);
        repeat (3) @(negedge clk);
        chk("R8 err sticky", int'(err), 1);

        // R7 restart with pin still high
        run = 1'b0;
        repeat (6) @(negedge clk);
        run = 1'b1;
        win(20, dce, de0, de1, ddbl);
        chk("R7 restart no event", de0, 0);
        park();

        // R2 / R3 divider sweep
        do_reset(2'b00);
        foreach (codes[i]) begin
            int c, n;
            c = codes[i];
            n = divisor(c);
            run = 1'b0;
            repeat (4) @(negedge clk);
            wr_reg(1'b1, 8'(c >> 2));
            wr_reg(1'b0, 8'(c & 3));
            @(negedge clk);
            run = 1'b1;
            k = 0;
            do begin
                @(negedge clk);
                k++;
            end while (!ce && k < 600);
            chk($sformatf("R3 latency code %0d", c), k, n + 1);
            win(1024, dce, de0, de1, ddbl);
            chk($sformatf("R2 pulses code %0d", c), dce, 1024 / n);
            chk($sformatf("R2 width code %0d", c), ddbl, 0);
        end
        chk("R10 legal writes keep err low", int'(err), 0);
        park();

        // R4 external count on pin 0
        wr_reg(1'b1, 8'h00);
        foreach (sels[i]) begin
            int s, e;
            s = sels[i];
            wr_reg(1'b0, 8'((s << 4) | 3));
            @(negedge clk); run = 1'b1;
            repeat (4) @(negedge clk);
            wave(0, 5, 4, dce, de0, de1);
            e = (s == 0) ? 4 : (s == 1) ? 5 : 9;
            chk($sformatf("R4 ext count sel %0d", s), dce, e);
            chk($sformatf("R5 pin0 events sel %0d", s), de0, e);
            park();
        end

        // R5 pin 1 sensitivity under internal code
        wr_reg(1'b0, 8'h00);
        foreach (sels[i]) begin
            int s, e;
            s = sels[i];
            wr_reg(1'b0, 8'(s << 6));
            @(negedge clk); run = 1'b1;
            repeat (4) @(negedge clk);
            wave(1, 5, 3, dce, de0, de1);
            e = (s == 0) ? 4 : (s == 1) ? 5 : 9;
            chk($sformatf("R5 pin1 events sel %0d", s), de1, e);
            chk($sformatf("R5 pin0 quiet sel %0d", s), de0, 0);
            park();
        end

        // R5 no events while stopped
        wr_reg(1'b0, 8'hF0);
        wave(1, 3, 3, dce, de0, de1);
        chk("R5 stopped pin1", de1, 0);
        wave(0, 3, 3, dce, de0, de1);
        chk("R5 stopped pin0", de0, 0);
        park();

        // R9 forbidden clock code 111
        do_reset(2'b00);
        wr_reg(1'b1, 8'h01);
        wr_reg(1'b0, 8'h03);
        chk("R9 err on code 111", int'(err), 1);
        rd_reg(1'b0, v); chk("R9 mode stored", v, 8'h03);
        rd_reg(1'b1, v); chk("R9 ext stored", v, 8'h01);
        @(negedge clk); run = 1'b1;
        win(600, dce, de0, de1, ddbl);
        chk("R9 no count on 111", dce, 0);
        park();

        // R9 forbidden sensitivity on pin 1
        do_reset(2'b00);
        wr_reg(1'b0, 8'h80);
        chk("R9 err on sel 10", int'(err), 1);
        rd_reg(1'b0, v); chk("R9 sel stored", v, 8'h80);
        @(negedge clk); run = 1'b1;
        repeat (4) @(negedge clk);
        wave(1, 3, 3, dce, de0, de1);
        chk("R9 no events on sel 10", de1, 0);
        park();

        // R10 field layout and zero bits
        do_reset(2'b00);
        wr_reg(1'b0, 8'hFF);
        rd_reg(1'b0, v); chk("R10 mode readback", v, 8'hF3);
        wr_reg(1'b1, 8'hFE);
        rd_reg(1'b1, v); chk("R10 ext readback", v, 8'h00);
        chk("R10 err low", int'(err), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule